// File: doc/BRIEF.md
# Receive Queue Command and DMA Control

This block holds the command bits a host uses to manage the reading of received frames. One bit arms automatic dequeue: each time the buffer manager signals that the host has finished reading the current frame, the block issues a one-cycle request to advance the read side to the next received frame. A second bit asks the buffer manager to drop the current errored receive frame. That bit stays set and visible to the host until the buffer manager confirms the release, then clears itself.

A third bit switches the host port into DMA mode. With the command/data select low, chip-select plus the read strobe reads receive-buffer data, and chip-select plus the write strobe writes transmit-buffer data. While DMA mode is on, every register access other than to this control register is blocked: blocked reads return zero and blocked writes go nowhere. DMA mode ends only through a register write, with the command select high, that clears the DMA bit. The frame memory itself lies outside this block.

Top module: `rxq_cmd_dma_ctrl`

## Requirements
- R1: After reset the control word reads 0, DMA mode is off, and `release_req` and `dequeue_req` are 0.
- R2: A read of the control address with `host_cmd`=1 returns auto-dequeue in bit 4, DMA mode in bit 3 and release-pending in bit 0. All other bits, including reserved bits 2:1, read 0, and writes to them are ignored.
- R3: While bit 4 is set, a rising edge on `frame_read_done` produces `dequeue_req` high for exactly one cycle, in the cycle after the edge. With bit 4 clear, no pulse appears.
- R4: Writing 1 to bit 3 enters DMA mode. In DMA mode with `host_cmd`=0, `host_cs`&`host_rd` drives `rxq_rd_en` and returns `buf_rdata`, and `host_cs`&`host_wr` drives `txq_wr_en`. Outside DMA mode both buffer strobes stay 0.
- R5: In DMA mode, accesses to any other register address give `ext_rd_en`=`ext_wr_en`=0 and read data 0.
- R6: DMA mode ends only when a write with `host_cmd`=1 to the control address carries 0 in bit 3. Accesses with `host_cmd`=0 never change the control word.
- R7: Writing 1 to bit 0 raises `release_req` and sets bit 0 in the next cycle. They stay 1 until `release_done` is seen, and are 0 in the cycle after. Writing 0 to bit 0 has no effect.
- R8: A write of 1 to bit 0 while a release is pending is ignored, including in the cycle in which `release_done` clears it.
- R9: Outside DMA mode, a register access with `host_cmd`=1 to an address other than the control address drives `ext_rd_en`/`ext_wr_en` from `host_cs` and the strobes, and reads return `ext_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_cmd | input | 1 | 1 = register access, 0 = data access |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Register write data |
| host_rdata | output | DATA_W | Read data returned to the host |
| ext_rdata | input | DATA_W | Read data from the other registers |
| buf_rdata | input | DATA_W | Receive-buffer data for DMA reads |
| ext_rd_en | output | 1 | Read enable to the other registers |
| ext_wr_en | output | 1 | Write enable to the other registers |
| rxq_rd_en | output | 1 | DMA read strobe to the receive buffer |
| txq_wr_en | output | 1 | DMA write strobe to the transmit buffer |
| frame_read_done | input | 1 | Host has finished reading the current frame |
| release_done | input | 1 | Buffer manager has released the errored frame |
| dequeue_req | output | 1 | One-cycle request to move to the next frame |
| release_req | output | 1 | Errored-frame release pending |
| dma_active | output | 1 | DMA mode is on |

## Verification
The access gating and read-data path are combinational, so the bench sets each strobe pattern just after a falling edge and compares the results 1 ns later, before any rising edge can act on them. A control write takes effect at the first rising edge. Its readback and state outputs are compared at the next falling edge. `dequeue_req` is due one edge after `frame_read_done` rises and is gone one edge later. `release_req` drops one edge after `release_done`. The bench samples each of these at the falling edge that follows the edge in question.

// File: rtl/rxqc_pkg.sv
package rxqc_pkg;
   localparam int unsigned BIT_ADEQ = 4;
   localparam int unsigned BIT_DMA  = 3;
   localparam int unsigned BIT_REL  = 0;
   localparam int unsigned MIN_DATA_W = BIT_ADEQ + 1;

   typedef struct packed {
      logic adeq;
      logic dma;
      logic rel;
   } rxqc_state_t;
endpackage

// File: rtl/rxqc_mode_reg.sv
module rxqc_mode_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  logic wd_adeq,
   input  logic wd_dma,
   output logic adeq_q,
   output logic dma_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adeq_q <= 1'b0;
         dma_q  <= 1'b0;
      end else if (wr_hit) begin
         adeq_q <= wd_adeq;
         dma_q  <= wd_dma;
      end
   end
endmodule

// File: rtl/rxqc_release.sv
module rxqc_release (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic done,
   output logic pending
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending <= 1'b0;
      else if (pending)
         pending <= !done;
      else
         pending <= set_req;
   end
endmodule

// File: rtl/rxqc_dequeue.sv
module rxqc_dequeue #(
   parameter bit ON_EDGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic frame_done,
   output logic pulse
);
   logic trig;

   generate
      if (ON_EDGE) begin : g_edge
         logic done_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) done_q <= 1'b0;
            else        done_q <= frame_done;
         end
         assign trig = frame_done && !done_q;
      end else begin : g_level
         assign trig = frame_done;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= trig && enable;
   end
endmodule

// File: rtl/rxqc_access_gate.sv
module rxqc_access_gate #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 16,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
   input  logic              cs,
   input  logic              rd,
   input  logic              wr,
   input  logic              cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic              dma,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] ext_rdata,
   input  logic [DATA_W-1:0] buf_rdata,
   output logic              ctrl_wr,
   output logic              ext_rd_en,
   output logic              ext_wr_en,
   output logic              rxq_rd_en,
   output logic              txq_wr_en,
   output logic [DATA_W-1:0] rdata
);
   logic reg_cyc, dat_cyc, at_ctrl, ctrl_rd;

   assign reg_cyc   = cs && cmd;
   assign dat_cyc   = cs && !cmd && dma;
   assign at_ctrl   = (addr == CTRL_ADDR);
   assign ctrl_wr   = reg_cyc && at_ctrl && wr;
   assign ctrl_rd   = reg_cyc && at_ctrl && rd;
   assign ext_rd_en = reg_cyc && !at_ctrl && !dma && rd;
   assign ext_wr_en = reg_cyc && !at_ctrl && !dma && wr;
   assign rxq_rd_en = dat_cyc && rd;
   assign txq_wr_en = dat_cyc && wr;

   always_comb begin
      if (ctrl_rd)        rdata = ctrl_word;
      else if (ext_rd_en) rdata = ext_rdata;
      else if (rxq_rd_en) rdata = buf_rdata;
      else                rdata = '0;
   end
endmodule

// File: rtl/rxq_cmd_dma_ctrl.sv
module rxq_cmd_dma_ctrl
   import rxqc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h44,
   parameter bit          DEQ_ON_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic              host_cmd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [DATA_W-1:0] ext_rdata,
   input  logic [DATA_W-1:0] buf_rdata,
   output logic              ext_rd_en,
   output logic              ext_wr_en,
   output logic              rxq_rd_en,
   output logic              txq_wr_en,
   input  logic              frame_read_done,
   input  logic              release_done,
   output logic              dequeue_req,
   output logic              release_req,
   output logic              dma_active
);
   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
         $error("rxq_cmd_dma_ctrl: DATA_W too narrow for control bits");
      end
      if (ADDR_W < 1) begin : g_bad_addr_w
         $error("rxq_cmd_dma_ctrl: ADDR_W must be at least 1");
      end
   endgenerate

   rxqc_state_t      st;
   logic             ctrl_wr;
   logic             adeq_q;
   logic [DATA_W-1:0] ctrl_word;

   always_comb begin
      ctrl_word           = '0;
      ctrl_word[BIT_ADEQ] = st.adeq;
      ctrl_word[BIT_DMA]  = st.dma;
      ctrl_word[BIT_REL]  = st.rel;
   end

   rxqc_access_gate #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
   ) i_gate (
      .cs(host_cs), .rd(host_rd), .wr(host_wr), .cmd(host_cmd),
      .addr(host_addr), .dma(st.dma), .ctrl_word(ctrl_word),
      .ext_rdata(ext_rdata), .buf_rdata(buf_rdata),
      .ctrl_wr(ctrl_wr), .ext_rd_en(ext_rd_en), .ext_wr_en(ext_wr_en),
      .rxq_rd_en(rxq_rd_en), .txq_wr_en(txq_wr_en), .rdata(host_rdata)
   );

   rxqc_mode_reg i_mode (
      .clk(clk), .rst_n(rst_n), .wr_hit(ctrl_wr),
      .wd_adeq(host_wdata[BIT_ADEQ]), .wd_dma(host_wdata[BIT_DMA]),
      .adeq_q(adeq_q), .dma_q(st.dma)
   );
   assign st.adeq = adeq_q;

   rxqc_release i_rel (
      .clk(clk), .rst_n(rst_n),
      .set_req(ctrl_wr && host_wdata[BIT_REL]),
      .done(release_done), .pending(st.rel)
   );

   rxqc_dequeue #(.ON_EDGE(DEQ_ON_EDGE)) i_deq (
      .clk(clk), .rst_n(rst_n), .enable(adeq_q),
      .frame_done(frame_read_done), .pulse(dequeue_req)
   );

   assign release_req = st.rel;
   assign dma_active  = st.dma;
endmodule

// File: rtl/rxqc_checker.sv
module rxqc_checker
   import rxqc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h44,
   parameter bit          DEQ_ON_EDGE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_cs,
   input logic              host_wr,
   input logic              host_cmd,
   input logic [ADDR_W-1:0] host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              ext_rd_en,
   input logic              ext_wr_en,
   input logic              rxq_rd_en,
   input logic              txq_wr_en,
   input logic              frame_read_done,
   input logic              release_done,
   input logic              dequeue_req,
   input logic              release_req,
   input logic              dma_active,
   input logic              adeq_q
);
   generate
      if (DEQ_ON_EDGE) begin : g_edge_chk
         AST_DEQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            dequeue_req |=> !dequeue_req); // R3
      end
   endgenerate

   AST_DEQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      dequeue_req |-> $past(adeq_q && frame_read_done)); // R3

   AST_BUF_DMA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (rxq_rd_en || txq_wr_en) |-> dma_active); // R4

   AST_DMA_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      dma_active |-> (!ext_rd_en && !ext_wr_en)); // R5

   AST_DMA_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_active) |-> $past(host_cs && host_cmd && host_wr &&
                                  host_addr == CTRL_ADDR && !host_wdata[BIT_DMA])); // R6

   AST_REL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (release_req && !release_done) |=> release_req); // R7

   AST_REL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (release_req && release_done) |=> !release_req); // R8
endmodule

bind rxq_cmd_dma_ctrl rxqc_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .DEQ_ON_EDGE(DEQ_ON_EDGE)
) i_rxqc_checker (
   .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_wr(host_wr),
   .host_cmd(host_cmd), .host_addr(host_addr), .host_wdata(host_wdata),
   .ext_rd_en(ext_rd_en), .ext_wr_en(ext_wr_en), .rxq_rd_en(rxq_rd_en),
   .txq_wr_en(txq_wr_en), .frame_read_done(frame_read_done),
   .release_done(release_done), .dequeue_req(dequeue_req),
   .release_req(release_req), .dma_active(dma_active), .adeq_q(adeq_q)
);

// File: tb/test_rxq_cmd_dma_ctrl.sv
`timescale 1ns/1ps
module test_rxq_cmd_dma_ctrl;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam logic [AW-1:0] CTRL = 8'h44;
   localparam logic [AW-1:0] OTHER = 8'h10;
   localparam logic [DW-1:0] EXT_D = 16'hBEEF;
   localparam logic [DW-1:0] BUF_D = 16'h1234;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cs = 0, rd = 0, wr = 0, cmd = 0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic ext_rd, ext_wr, rxq_rd, txq_wr;
   logic frd = 0, rdone = 0, deq, rreq, dma;
   int vectors = 0, miscompares = 0;

   always #4 clk = ~clk;

   rxq_cmd_dma_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(CTRL)) i_rxq_cmd_dma_ctrl (
      .clk(clk), .rst_n(rst_n), .host_cs(cs), .host_rd(rd), .host_wr(wr),
      .host_cmd(cmd), .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata),
      .ext_rdata(EXT_D), .buf_rdata(BUF_D), .ext_rd_en(ext_rd), .ext_wr_en(ext_wr),
      .rxq_rd_en(rxq_rd), .txq_wr_en(txq_wr), .frame_read_done(frd),
      .release_done(rdone), .dequeue_req(deq), .release_req(rreq), .dma_active(dma)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic c, input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cs = 1; wr = 1; cmd = c; addr = a; wdata = d;
      @(negedge clk);
      cs = 0; wr = 0; cmd = 0; wdata = '0;
   endtask

   task automatic read_ctrl(input string req, input logic [DW-1:0] exp);
      cs = 1; rd = 1; cmd = 1; addr = CTRL;
      #1 chk(req, rdata, exp);
      #1 cs = 0; rd = 0; cmd = 0;
   endtask

   task automatic gate_sweep(input logic d);
      for (int p = 0; p < 16; p++) begin
         logic pc, pr, pw, pm;
         logic [DW-1:0] er;
         {pc, pr, pw, pm} = 4'(p);
         cs = pc; rd = pr; wr = pw; cmd = pm; addr = OTHER;
         #1;
         chk("R9/R5 ext_rd_en", {15'd0, ext_rd}, {15'd0, pc & pm & pr & !d});
         chk("R9/R5 ext_wr_en", {15'd0, ext_wr}, {15'd0, pc & pm & pw & !d});
         chk("R4 rxq_rd_en", {15'd0, rxq_rd}, {15'd0, pc & !pm & pr & d});
         chk("R4 txq_wr_en", {15'd0, txq_wr}, {15'd0, pc & !pm & pw & d});
         er = (pc & pm & pr & !d) ? EXT_D : (pc & !pm & pr & d) ? BUF_D : '0;
         chk("R4/R5/R9 rdata", rdata, er);
         #1 cs = 0; rd = 0; wr = 0; cmd = 0;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      read_ctrl("R1 ctrl after reset", '0);
      chk("R1 dma_active", {15'd0, dma}, '0);
      chk("R1 release_req", {15'd0, rreq}, '0);
      chk("R1 dequeue_req", {15'd0, deq}, '0);

      // sweep of low control bits with reserved/high bits set
      for (int v = 0; v < 32; v++) begin
         logic [DW-1:0] exp;
         exp = DW'(v) & 16'h0019;
         bus_write(1'b1, CTRL, {11'h5A5, 5'(v)});
         read_ctrl("R2 readback", exp);
         chk("R4 dma_active", {15'd0, dma}, {15'd0, exp[3]});
         chk("R7 release_req", {15'd0, rreq}, {15'd0, exp[0]});
         gate_sweep(exp[3]);
         // R6 data-cycle write to control address leaves it unchanged
         bus_write(1'b0, CTRL, 16'h0000);
         read_ctrl("R6 cmd-low write ignored", exp);
         if (exp[0]) begin
            bus_write(1'b1, CTRL, 16'h0000 | (exp & 16'h0018));
            chk("R7 writing 0 to bit0 keeps pending", {15'd0, rreq}, 16'd1);
            @(negedge clk) rdone = 1;
            @(negedge clk) rdone = 0;
            chk("R7 cleared after done", {15'd0, rreq}, '0);
         end
         bus_write(1'b1, CTRL, 16'h0000);
         chk("R6 dma exit by register write", {15'd0, dma}, '0);
      end

      // R3 auto-dequeue
      bus_write(1'b1, CTRL, 16'h0010);
      @(negedge clk) frd = 1;
      @(negedge clk);
      chk("R3 pulse in cycle after edge", {15'd0, deq}, 16'd1);
      @(negedge clk);
      chk("R3 pulse lasts one cycle", {15'd0, deq}, '0);
      frd = 0;
      @(negedge clk) frd = 1;
      @(negedge clk) frd = 0;
      chk("R3 second frame pulse", {15'd0, deq}, 16'd1);
      bus_write(1'b1, CTRL, 16'h0000);
      @(negedge clk) frd = 1;
      @(negedge clk) frd = 0;
      chk("R3 no pulse when disabled", {15'd0, deq}, '0);
      @(negedge clk);
      chk("R3 no pulse when disabled (late)", {15'd0, deq}, '0);

      // R7 / R8 release handshake
      bus_write(1'b1, CTRL, 16'h0001);
      repeat (4) @(negedge clk);
      chk("R7 held while waiting", {15'd0, rreq}, 16'd1);
      read_ctrl("R7 bit0 reads 1 while pending", 16'h0001);
      bus_write(1'b1, CTRL, 16'h0001);
      chk("R8 repeat request while pending", {15'd0, rreq}, 16'd1);
      @(negedge clk);
      cs = 1; wr = 1; cmd = 1; addr = CTRL; wdata = 16'h0001; rdone = 1;
      @(negedge clk);
      cs = 0; wr = 0; cmd = 0; wdata = '0; rdone = 0;
      chk("R8 write ignored in clearing cycle", {15'd0, rreq}, '0);
      read_ctrl("R8 bit0 reads 0", '0);
      bus_write(1'b1, CTRL, 16'h0001);
      chk("R7 new request after clear", {15'd0, rreq}, 16'd1);
      @(negedge clk) rdone = 1;
      @(negedge clk) rdone = 0;
      chk("R7 final clear", {15'd0, rreq}, '0);

      // R6 DMA persists across data cycles, ends only by register write
      bus_write(1'b1, CTRL, 16'h0008);
      bus_write(1'b0, OTHER, 16'h0000);
      bus_write(1'b1, OTHER, 16'h0000);
      chk("R6 dma persists", {15'd0, dma}, 16'd1);
      bus_write(1'b1, CTRL, 16'h0000);
      chk("R6 dma exit", {15'd0, dma}, '0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule